// File: doc/BRIEF.md
# Attribute-Driven Control Register Bank

A compact bank of 32-bit control and status registers behind a simple synchronous host port. Every bit of every register carries its own access attribute, fixed at build time: fixed/read-only, write-only, read/write, write-one-to-clear, write-once after reset, or lock-once. Hardware raises status events through a flat set-pulse bus. The live contents of all registers are driven out on a flat bus for the surrounding logic.

The host issues a single-cycle write (address, write strobe, data) or a single-cycle read (address, read strobe). Read data is registered. Two build-time tables translate each host address into a register index for reads and a separate index for writes. A location can therefore show one register when read and update another when written, or be read-only as a whole.

The block is fully parallel and has no sequencing states. Its only sequential elements are the register bits, one per-register write-once flag, one per-bit lock flag on lock-once bits, and the read-data register.

Top module: `regbank_top`

## Requirements
- R1: On reset every register bit loads its default. With the default build, the four registers (index 0..3, `ctrl_q` bits [32*i+31:32*i]) reset to 0x300000A5, 0x00000000, 0x12345678 and 0x00000000.
- R2: Read-only bits always hold their fixed default and ignore host writes and set pulses. In the default build these are register 0 bits [31:28], fixed at 0x3.
- R3: Read/write bits take the written value on a write to their register. In the default build these are register 0 bits [7:0] and all of registers 2 and 3.
- R4: Write-only bits take the written value on `ctrl_q` but read back as 0. A read of any location leaves all register state unchanged. In the default build register 1 is entirely write-only.
- R5: A write-one-to-clear bit clears when written with 1 and is unchanged when written with 0. A set pulse on `hw_set` sets it. `hw_set` bits over non-clearable bits have no effect. In the default build these are register 0 bits [15:8].
- R6: When a set pulse and a clearing write reach the same write-one-to-clear bit in the same cycle, the bit ends at 1.
- R7: A write-once bit accepts only the first host write to its register after reset, then holds until the next reset. Any write to the register uses up that chance, even one carrying the current value. In the default build these are register 0 bits [23:16].
- R8: A lock-once bit accepts any number of writes of its non-locked value. Once its locked value has been written, it holds until reset. In the default build these are register 0 bits [27:24], locked value 1.
- R9: In the default build, address 0 reads and writes register 0 and address 1 does the same for register 1. Address 2 reads register 2 but writes register 3. Address 3 reads register 3 and ignores writes.
- R10: `rd_data` holds the read value from the clock edge that samples `rd_en` until the next read. Addresses with no read mapping (4..15 by default) return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Host word address |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 32 | Registered read data |
| hw_set | input | 128 | Per-bit set pulses from hardware (register i at bits 32*i+31:32*i) |
| ctrl_q | output | 128 | Live register contents, same layout as hw_set |

## Verification
A write or a set pulse changes `ctrl_q` at the same rising edge that samples it, so it is due one edge after the stimulus is applied. A read strobe produces `rd_data` at the next rising edge, and the value reflects the state before any write at that edge. The bench drives each operation on a falling edge and samples both outputs on the following falling edge. Its model advances by exactly one step per operation, with the read value taken from the model before the step.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [2:0] {
        ACC_RO   = 3'd0,
        ACC_WO   = 3'd1,
        ACC_RW   = 3'd2,
        ACC_W1C  = 3'd3,
        ACC_ONCE = 3'd4,
        ACC_LOCK = 3'd5
    } acc_e;

    localparam int DEF_REGS  = 4;
    localparam int DEF_W     = 32;
    localparam int DEF_ADDRS = 4;
    localparam int MAP_W     = 4;

    function automatic logic [DEF_REGS*DEF_W*3-1:0] default_acc();
        logic [DEF_REGS*DEF_W*3-1:0] v;
        acc_e a;
        v = '0;
        for (int r = 0; r < DEF_REGS; r++) begin
            for (int b = 0; b < DEF_W; b++) begin
                if (r == 0) begin
                    if (b < 8)       a = ACC_RW;
                    else if (b < 16) a = ACC_W1C;
                    else if (b < 24) a = ACC_ONCE;
                    else if (b < 28) a = ACC_LOCK;
                    else             a = ACC_RO;
                end else if (r == 1) begin
                    a = ACC_WO;
                end else begin
                    a = ACC_RW;
                end
                v[(r*DEF_W+b)*3 +: 3] = a;
            end
        end
        return v;
    endfunction

    function automatic logic [DEF_REGS*DEF_W-1:0] default_rst();
        return {32'h0000_0000, 32'h1234_5678, 32'h0000_0000, 32'h3000_00A5};
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int NUM_REGS  = 4,
    parameter int NUM_ADDRS = 4,
    parameter int ADDR_W    = 4,
    parameter logic [NUM_ADDRS*regbank_pkg::MAP_W-1:0] RD_MAP = '0,
    parameter logic [NUM_ADDRS*regbank_pkg::MAP_W-1:0] WR_MAP = '0
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    output logic [NUM_REGS-1:0]            wr_sel,
    output logic [regbank_pkg::MAP_W-1:0]  rd_idx,
    output logic                           rd_hit
);
    localparam int MW = regbank_pkg::MAP_W;

    logic [MW-1:0] wr_idx;
    logic          wr_hit;

    always_comb begin
        rd_idx = '0;
        wr_idx = '0;
        rd_hit = 1'b0;
        wr_hit = 1'b0;
        for (int a = 0; a < NUM_ADDRS; a++) begin
            if (addr == ADDR_W'(a)) begin
                rd_idx = RD_MAP[a*MW +: MW];
                wr_idx = WR_MAP[a*MW +: MW];
                rd_hit = (int'(RD_MAP[a*MW +: MW]) < NUM_REGS);
                wr_hit = (int'(WR_MAP[a*MW +: MW]) < NUM_REGS);
            end
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign wr_sel[r] = wr_en && wr_hit && (wr_idx == MW'(r));
    end

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
    parameter regbank_pkg::acc_e ACC = regbank_pkg::ACC_RW,
    parameter bit RST   = 1'b0,
    parameter bit LOCKV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic hw_set,
    input  logic once_done,
    output logic q,
    output logic rd_q
);
    import regbank_pkg::*;

    if (ACC == ACC_RO) begin : g_ro
        logic unused_in;
        assign unused_in = ^{clk, rst_n, wr_en, wr_bit, hw_set, once_done};
        assign q = RST;
    end else if (ACC == ACC_W1C) begin : g_w1c
        logic unused_in;
        assign unused_in = once_done;
        always_ff @(posedge clk) begin
            if (!rst_n)                q <= RST;
            else if (hw_set)           q <= 1'b1;
            else if (wr_en && wr_bit)  q <= 1'b0;
        end
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set |=> q);
        // R5
        zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_bit && !hw_set) |=> $stable(q));
    end else if (ACC == ACC_ONCE) begin : g_once
        logic unused_in;
        assign unused_in = hw_set;
        always_ff @(posedge clk) begin
            if (!rst_n)                  q <= RST;
            else if (wr_en && !once_done) q <= wr_bit;
        end
        // R7
        once_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && once_done) |=> $stable(q));
    end else if (ACC == ACC_LOCK) begin : g_lock
        logic unused_in;
        logic locked;
        assign unused_in = ^{hw_set, once_done};
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q      <= RST;
                locked <= 1'b0;
            end else if (wr_en && !locked) begin
                q      <= wr_bit;
                locked <= (wr_bit == LOCKV);
            end
        end
        // R8
        lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            locked |=> $stable(q));
    end else begin : g_rw
        logic unused_in;
        assign unused_in = ^{hw_set, once_done};
        always_ff @(posedge clk) begin
            if (!rst_n)     q <= RST;
            else if (wr_en) q <= wr_bit;
        end
    end

    assign rd_q = (ACC == ACC_WO) ? 1'b0 : q;

endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
    parameter int NUM_REGS  = regbank_pkg::DEF_REGS,
    parameter int DATA_W    = regbank_pkg::DEF_W,
    parameter int NUM_ADDRS = regbank_pkg::DEF_ADDRS,
    parameter int ADDR_W    = 4,
    parameter logic [NUM_REGS*DATA_W*3-1:0] ACC_MAP = regbank_pkg::default_acc(),
    parameter logic [NUM_REGS*DATA_W-1:0]   RST_VAL = regbank_pkg::default_rst(),
    parameter logic [NUM_REGS*DATA_W-1:0]   LOCK_VAL = '1,
    parameter logic [NUM_ADDRS*regbank_pkg::MAP_W-1:0] RD_MAP = {4'd3, 4'd2, 4'd1, 4'd0},
    parameter logic [NUM_ADDRS*regbank_pkg::MAP_W-1:0] WR_MAP = {4'hF, 4'd3, 4'd1, 4'd0}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_en,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [NUM_REGS*DATA_W-1:0]  hw_set,
    output logic [NUM_REGS*DATA_W-1:0]  ctrl_q
);
    import regbank_pkg::*;

    localparam int NBITS = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] once_done;
    logic [MAP_W-1:0]    rd_idx;
    logic                rd_hit;
    logic [NBITS-1:0]    rd_vis;
    logic [DATA_W-1:0]   rd_word;

    regbank_decode #(
        .NUM_REGS (NUM_REGS),
        .NUM_ADDRS(NUM_ADDRS),
        .ADDR_W   (ADDR_W),
        .RD_MAP   (RD_MAP),
        .WR_MAP   (WR_MAP)
    ) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .wr_sel(wr_sel),
        .rd_idx(rd_idx),
        .rd_hit(rd_hit)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)         once_done[r] <= 1'b0;
            else if (wr_sel[r]) once_done[r] <= 1'b1;
        end
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            regbank_cell #(
                .ACC  (acc_e'(ACC_MAP[(r*DATA_W+b)*3 +: 3])),
                .RST  (RST_VAL[r*DATA_W+b]),
                .LOCKV(LOCK_VAL[r*DATA_W+b])
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_sel[r]),
                .wr_bit   (wr_data[b]),
                .hw_set   (hw_set[r*DATA_W+b]),
                .once_done(once_done[r]),
                .q        (ctrl_q[r*DATA_W+b]),
                .rd_q     (rd_vis[r*DATA_W+b])
            );
        end
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_hit && rd_idx == MAP_W'(r)) rd_word = rd_vis[r*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> (rd_data == '0));

    // R4
    read_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (hw_set == '0)) |=> $stable(ctrl_q));

endmodule

// File: tb/regbank_top_test.sv
module regbank_top_test;

    localparam logic [31:0] RWM  = 32'h0000_00FF;
    localparam logic [31:0] W1CM = 32'h0000_FF00;
    localparam logic [31:0] ONCM = 32'h00FF_0000;
    localparam logic [31:0] LKM  = 32'h0F00_0000;
    localparam logic [31:0] ROM  = 32'hF000_0000;
    localparam logic [31:0] ROV  = 32'h3000_0000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   addr;
    logic         wr_en;
    logic [31:0]  wr_data;
    logic         rd_en;
    logic [31:0]  rd_data;
    logic [127:0] hw_set;
    logic [127:0] ctrl_q;

    int checks = 0;
    int failures = 0;

    logic [31:0] m0, m1, m2, m3, lk0;
    logic        once0;

    always #4 clk = ~clk;

    regbank_top uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .hw_set(hw_set), .ctrl_q(ctrl_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m0 = 32'h3000_00A5; m1 = '0; m2 = 32'h1234_5678; m3 = '0;
        lk0 = '0; once0 = 1'b0;
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return m0;
            4'd1: return 32'h0;
            4'd2: return m2;
            4'd3: return m3;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step(input bit wr, input logic [3:0] a, input logic [31:0] d, input logic [31:0] hs0);
        logic [31:0] n, clr, fr;
        n = m0;
        clr = (wr && a == 4'd0) ? d : 32'h0;
        n = (n & ~W1CM) | (((m0 & ~clr) | hs0) & W1CM);
        if (wr && a == 4'd0) begin
            n = (n & ~RWM) | (d & RWM);
            if (!once0) n = (n & ~ONCM) | (d & ONCM);
            fr = LKM & ~lk0;
            n = (n & ~fr) | (d & fr);
            lk0 = lk0 | (fr & d);
            once0 = 1'b1;
        end
        m0 = (n & ~ROM) | ROV;
        if (wr && a == 4'd1) m1 = d;
        if (wr && a == 4'd2) m3 = d;
    endtask

    // one operation: drive at falling edge, check at the next falling edge
    task automatic op(input bit wr, input bit rd, input logic [3:0] a, input logic [31:0] d,
                      input logic [127:0] hs, input string tag);
        logic [31:0] er;
        addr = a; wr_en = wr; wr_data = d; rd_en = rd; hw_set = hs;
        er = exp_read(a);
        @(posedge clk);
        model_step(wr, a, d, hs[31:0]);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; hw_set = '0;
        chk(ctrl_q == {m3, m2, m1, m0}, tag, ctrl_q, {m3, m2, m1, m0});
        if (rd) chk(rd_data == er, {tag, " read"}, 128'(rd_data), 128'(er));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; hw_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset contents
        chk(ctrl_q == {32'h0, 32'h1234_5678, 32'h0, 32'h3000_00A5}, "R1 reset", ctrl_q,
            {32'h0, 32'h1234_5678, 32'h0, 32'h3000_00A5});
        op(0, 1, 4'd0, 0, '0, "R1 read0");
        op(0, 1, 4'd2, 0, '0, "R1 read2");
        // R7 first write carries the current once field value and uses up the chance
        op(1, 0, 4'd0, 32'h0000_00A5, '0, "R7 arm");
        op(1, 1, 4'd0, 32'hF0FF_0011, '0, "R7 frozen R2 R3");
        chk(ctrl_q[23:16] == 8'h00, "R7 once held", 128'(ctrl_q[23:16]), 128'h0);
        chk(ctrl_q[31:28] == 4'h3, "R2 fixed", 128'(ctrl_q[31:28]), 128'h3);
        // R8 lock-once
        op(1, 0, 4'd0, 32'h0000_0011, '0, "R8 unlocked write");
        op(1, 0, 4'd0, 32'h0500_0011, '0, "R8 lock 24,26");
        op(1, 1, 4'd0, 32'h0A00_0011, '0, "R8 lock 25,27");
        chk(ctrl_q[27:24] == 4'hF, "R8 all locked", 128'(ctrl_q[27:24]), 128'hF);
        op(1, 0, 4'd0, 32'h0000_0011, '0, "R8 held");
        // R5 set, clear by 1, keep by 0
        op(0, 0, 4'd0, 0, 128'h0000_FF00, "R5 set");
        op(1, 0, 4'd0, 32'h0000_0111, '0, "R5 clear bit8");
        op(1, 1, 4'd0, 32'h0000_0011, '0, "R5 zero write");
        chk(ctrl_q[15:8] == 8'hFE, "R5 w1c field", 128'(ctrl_q[15:8]), 128'hFE);
        op(0, 0, 4'd0, 0, {96'h0, 32'hFFFF_00FF}, "R5 set ignored off w1c");
        op(0, 0, 4'd0, 0, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0}, "R2 R5 set other regs");
        // R6 set and clear together
        op(1, 0, 4'd0, 32'h0000_0211, 128'h0000_0200, "R6 set wins");
        chk(ctrl_q[9] == 1'b1, "R6 bit9", 128'(ctrl_q[9]), 128'h1);
        // R4 write-only
        op(1, 0, 4'd1, 32'hCAFE_F00D, '0, "R4 wo write");
        op(0, 1, 4'd1, 0, '0, "R4 wo read zero");
        chk(ctrl_q[63:32] == 32'hCAFE_F00D, "R4 wo kept", 128'(ctrl_q[63:32]), 128'hCAFE_F00D);
        // R9 split location
        op(1, 0, 4'd2, 32'hDEAD_BEEF, '0, "R9 split write");
        op(0, 1, 4'd2, 0, '0, "R9 read reg2");
        op(0, 1, 4'd3, 0, '0, "R9 read reg3");
        op(1, 1, 4'd3, 32'h1111_2222, '0, "R9 addr3 write ignored");
        // R10 unmapped
        op(1, 0, 4'd9, 32'hFFFF_FFFF, '0, "R10 unmapped write");
        op(0, 1, 4'd12, 0, '0, "R10 unmapped read");
        // R7 after a fresh reset the first write is taken
        do_reset();
        op(1, 0, 4'd0, 32'h005C_0000, '0, "R7 first write");
        op(1, 1, 4'd0, 32'h00A3_0000, '0, "R7 second write");
        chk(ctrl_q[23:16] == 8'h5C, "R7 value", 128'(ctrl_q[23:16]), 128'h5C);
        // random mix R3 R4 R5 R6 R8 R9 R10
        for (int i = 0; i < 400; i++) begin
            logic [127:0] hs;
            hs = ($urandom % 4 == 0) ? {$urandom, $urandom, $urandom, $urandom} : '0;
            op($urandom % 2 == 0, $urandom % 2 == 0, 4'($urandom % 6), $urandom, hs, "R3 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule